// File: doc/BRIEF.md
# DMA Cycle-Stealing Bus Arbiter

This block sits between a processor core and the system memory bus. It runs two DMA engines that take bus cycles away from the processor. The first is a sample fetcher: it reads one byte for an audio sample unit whenever that unit's buffer runs dry and bytes remain to be played. The second is a bulk copier: a processor write names a 256-byte source page, and the copier moves that page into the sprite memory. Each byte is read from the bus and then written out on a dedicated sprite-memory port.

While either engine owns the bus, the arbiter holds the processor stall line high. A stalled processor issues no transaction and repeats its pending read once it is released. The number of cycles a sample fetch costs depends on where the request lands. A processor read is halted. A processor write cannot be halted, so it is allowed to finish first. Inside a bulk copy, the fetch is slotted between byte pairs. A free-running stolen-cycle counter exposes the total stall length.

The sample address is held internally. It can be loaded, it advances after every fetched byte, and it wraps into the upper half of the address space. The remaining-byte count lives outside the block, and it is decremented on every fetched-byte pulse.

Top module: `dma_steal_arb`

## Requirements
- R1: A sample request is raised in a cycle where `smpEmpty` and `smpRemain` are both 1 and no fetch is in flight. The request lands in the following cycle, so no stall is seen in the request cycle itself.
- R2: A sample request landing on a processor read cycle (`cpuRnW`=1) stalls the processor for exactly 4 cycles, starting with the landing cycle.
- R3: A sample request landing on a processor write cycle (`cpuRnW`=0) leaves the landing cycle unstalled and then stalls the processor for exactly 3 cycles.
- R4: A pulse on `sprTrig` with page P copies bytes from addresses {P,0x00} to {P,0xFF}. Each byte takes one bus read followed by one sprite-port write, and `oamAddr` counts upward from 0 to 255.
- R5: A copy with no sample fetch stalls the processor for 513 cycles. It stalls for 514 cycles when `oddCycle` is 1 in the first stalled cycle, which adds one alignment cycle before the first read.
- R6: A sample request landing on the first stalled cycle of a copy, or on any read or write of a copy other than the last pair, lengthens the copy by 2 cycles.
- R7: A sample request landing on the alignment cycle lengthens the copy by 1 cycle.
- R8: A sample request landing on either cycle of the final read/write pair lengthens the copy by 3 cycles.
- R9: A sample fetch slotted into a copy does not skip or repeat any sprite byte; all 256 writes still occur, in index order.
- R10: The fetched byte appears on `smpByte` with a one-cycle `smpValid` pulse in the cycle after the bus read, exactly once per request.
- R11: The sample address is loaded by `smpLoad`, increments by one after each fetched byte, and wraps from 0xFFFF to 0x8000. It resets to 0x8000.
- R12: `stallCount` increments once for every cycle with `cpuStall`=1 and holds otherwise. Every DMA bus read happens with `cpuStall`=1.
- R13: With `smpRemain`=0, an empty sample buffer raises no request: there is no stall, no bus read and no change of `stallCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRnW | input | 1 | Processor bus cycle kind this cycle: 1 read, 0 write |
| oddCycle | input | 1 | Cycle parity, 1 on odd processor cycles |
| sprTrig | input | 1 | Processor write to the copy trigger this cycle |
| sprPage | input | ADDR_W-IDX_W | Source page for the copy |
| smpEmpty | input | 1 | Sample buffer is empty |
| smpRemain | input | 1 | Remaining sample byte count is nonzero |
| smpLoad | input | 1 | Load the sample address |
| smpLoadAddr | input | ADDR_W | Sample address to load |
| memRdata | input | DATA_W | Read data from the memory bus |
| cpuStall | output | 1 | Processor stall, high on every stolen cycle |
| dmaRd | output | 1 | DMA drives a bus read this cycle |
| dmaAddr | output | ADDR_W | DMA bus address |
| oamWe | output | 1 | Sprite-memory write strobe |
| oamAddr | output | IDX_W | Sprite-memory write index |
| oamWdata | output | DATA_W | Sprite-memory write data |
| smpByte | output | DATA_W | Fetched sample byte |
| smpValid | output | 1 | Fetched byte valid pulse |
| stallCount | output | CNT_W | Running count of stolen cycles |

## Verification
Sample fetches are landed on both processor reads and processor writes. Because each of these costs a different number of stolen cycles, a design that ignores the bus direction is caught. Copies are started on both parities, first without a sample fetch and then with one landed on the halt cycle, the alignment cycle, a mid-copy read, a mid-copy write and each cycle of the final pair. This separates the 1, 2 and 3 cycle penalties, and it also checks that the byte sequence survives the insertion. Random landing positions and a load just below the wrap point exercise the address counter alongside the penalties.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HALT,
    ST_ALIGN,
    ST_SPR_RD,
    ST_SPR_WR,
    ST_SMP_WAIT,
    ST_SMP_RD
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sprRd;
    logic sprWr;
    logic smpRd;
    logic idxClr;
    logic idxInc;
    logic pageLd;
    logic stall;
  } dpStrobe_t;

endpackage

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
  import dma_steal_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuRnW,
  input  logic      oddCycle,
  input  logic      sprTrig,
  input  logic      smpEmpty,
  input  logic      smpRemain,
  input  logic      idxLast,
  input  logic      smpValid,
  output dpStrobe_t strb,
  output logic      cpuStall
);

  arbState_t state, stateNxt, retState, retNxt;
  logic [1:0] dummyCnt, dummyNxt;
  logic armed, armNxt;
  logic reqPend, reqNxt;
  logic busy;

  // a fetch is in flight from request until its byte has been handed over
  assign busy = reqPend | armed | smpValid |
                (state == ST_SMP_WAIT) | (state == ST_SMP_RD);
  assign reqNxt = smpEmpty & smpRemain & ~busy;

  // a landing on a processor read halts that read; a write runs to completion
  assign cpuStall = (state != ST_IDLE) | (reqPend & cpuRnW);

  always_comb begin
    stateNxt = state;
    retNxt   = retState;
    dummyNxt = dummyCnt;
    armNxt   = armed;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (sprTrig) begin
          strb.pageLd = 1'b1;
          strb.idxClr = 1'b1;
        end
        if (reqPend) begin
          stateNxt = ST_SMP_WAIT;
          dummyNxt = 2'd2;
          retNxt   = sprTrig ? ST_HALT : ST_IDLE;
        end else if (sprTrig) begin
          stateNxt = ST_HALT;
        end
      end
      ST_HALT: begin
        if (reqPend) begin
          stateNxt = ST_SMP_WAIT;
          dummyNxt = 2'd1;
          retNxt   = oddCycle ? ST_ALIGN : ST_SPR_RD;
        end else begin
          stateNxt = oddCycle ? ST_ALIGN : ST_SPR_RD;
        end
      end
      ST_ALIGN: begin
        // the alignment cycle doubles as the dummy cycle of a fetch
        if (reqPend) begin
          stateNxt = ST_SMP_RD;
          retNxt   = ST_SPR_RD;
        end else begin
          stateNxt = ST_SPR_RD;
        end
      end
      ST_SPR_RD: begin
        strb.sprRd = 1'b1;
        stateNxt   = ST_SPR_WR;
        if (reqPend) armNxt = 1'b1;
      end
      ST_SPR_WR: begin
        strb.sprWr = 1'b1;
        armNxt     = 1'b0;
        if (idxLast) begin
          if (reqPend | armed) begin
            stateNxt = ST_SMP_WAIT;
            dummyNxt = 2'd2;
            retNxt   = ST_IDLE;
          end else begin
            stateNxt = ST_IDLE;
          end
        end else begin
          strb.idxInc = 1'b1;
          if (reqPend | armed) begin
            stateNxt = ST_SMP_WAIT;
            dummyNxt = 2'd1;
            retNxt   = ST_SPR_RD;
          end else begin
            stateNxt = ST_SPR_RD;
          end
        end
      end
      ST_SMP_WAIT: begin
        if (dummyCnt == 2'd1) stateNxt = ST_SMP_RD;
        else dummyNxt = dummyCnt - 2'd1;
      end
      ST_SMP_RD: begin
        strb.smpRd = 1'b1;
        stateNxt   = retState;
      end
      default: stateNxt = ST_IDLE;
    endcase
    strb.stall = cpuStall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retState <= ST_IDLE;
      dummyCnt <= '0;
      armed    <= 1'b0;
      reqPend  <= 1'b0;
    end else begin
      state    <= stateNxt;
      retState <= retNxt;
      dummyCnt <= dummyNxt;
      armed    <= armNxt;
      reqPend  <= reqNxt;
    end
  end

endmodule

// File: rtl/dma_steal_dp.sv
module dma_steal_dp
  import dma_steal_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] SMP_BASE = 16'h8000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strb,
  input  logic [ADDR_W-IDX_W-1:0] sprPage,
  input  logic                    smpLoad,
  input  logic [ADDR_W-1:0]       smpLoadAddr,
  input  logic [DATA_W-1:0]       memRdata,
  output logic                    dmaRd,
  output logic [ADDR_W-1:0]       dmaAddr,
  output logic                    oamWe,
  output logic [IDX_W-1:0]        oamAddr,
  output logic [DATA_W-1:0]       oamWdata,
  output logic [DATA_W-1:0]       smpByte,
  output logic                    smpValid,
  output logic [CNT_W-1:0]        stallCount,
  output logic                    idxLast
);

  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic [PAGE_W-1:0] pageReg;
  logic [IDX_W-1:0]  idxReg;
  logic [DATA_W-1:0] copyLatch;
  logic [ADDR_W-1:0] smpAddr;

  assign idxLast  = (idxReg == '1);
  assign dmaRd    = strb.sprRd | strb.smpRd;
  assign oamWe    = strb.sprWr;
  assign oamAddr  = idxReg;
  assign oamWdata = copyLatch;

  always_comb begin
    if (strb.smpRd)      dmaAddr = smpAddr;
    else if (strb.sprRd) dmaAddr = {pageReg, idxReg};
    else                 dmaAddr = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg    <= '0;
      idxReg     <= '0;
      copyLatch  <= '0;
      smpAddr    <= SMP_BASE;
      smpByte    <= '0;
      smpValid   <= 1'b0;
      stallCount <= '0;
    end else begin
      if (strb.pageLd) pageReg <= sprPage;
      if (strb.idxClr)      idxReg <= '0;
      else if (strb.idxInc) idxReg <= idxReg + 1'b1;
      if (strb.sprRd) copyLatch <= memRdata;
      if (smpLoad)          smpAddr <= smpLoadAddr;
      else if (strb.smpRd)  smpAddr <= (smpAddr == ADDR_TOP) ? SMP_BASE : smpAddr + 1'b1;
      if (strb.smpRd) smpByte <= memRdata;
      smpValid <= strb.smpRd;
      if (strb.stall) stallCount <= stallCount + 1'b1;
    end
  end

endmodule

// File: rtl/dma_steal_arb.sv
module dma_steal_arb
  import dma_steal_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] SMP_BASE = 16'h8000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuRnW,
  input  logic                    oddCycle,
  input  logic                    sprTrig,
  input  logic [ADDR_W-IDX_W-1:0] sprPage,
  input  logic                    smpEmpty,
  input  logic                    smpRemain,
  input  logic                    smpLoad,
  input  logic [ADDR_W-1:0]       smpLoadAddr,
  input  logic [DATA_W-1:0]       memRdata,
  output logic                    cpuStall,
  output logic                    dmaRd,
  output logic [ADDR_W-1:0]       dmaAddr,
  output logic                    oamWe,
  output logic [IDX_W-1:0]        oamAddr,
  output logic [DATA_W-1:0]       oamWdata,
  output logic [DATA_W-1:0]       smpByte,
  output logic                    smpValid,
  output logic [CNT_W-1:0]        stallCount
);

  dpStrobe_t strb;
  logic idxLast;

  dma_steal_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuRnW   (cpuRnW),
    .oddCycle (oddCycle),
    .sprTrig  (sprTrig),
    .smpEmpty (smpEmpty),
    .smpRemain(smpRemain),
    .idxLast  (idxLast),
    .smpValid (smpValid),
    .strb     (strb),
    .cpuStall (cpuStall)
  );

  dma_steal_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W),
    .SMP_BASE(SMP_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sprPage    (sprPage),
    .smpLoad    (smpLoad),
    .smpLoadAddr(smpLoadAddr),
    .memRdata   (memRdata),
    .dmaRd      (dmaRd),
    .dmaAddr    (dmaAddr),
    .oamWe      (oamWe),
    .oamAddr    (oamAddr),
    .oamWdata   (oamWdata),
    .smpByte    (smpByte),
    .smpValid   (smpValid),
    .stallCount (stallCount),
    .idxLast    (idxLast)
  );

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuStall,
  input logic             dmaRd,
  input logic             oamWe,
  input logic             smpValid,
  input logic [CNT_W-1:0] stallCount
);

  p_dma_stall_r12: assert property (@(posedge clk) disable iff (!rstN)
    dmaRd |-> cpuStall)
    else $error("DMA bus read without processor stall");

  p_count_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |=> stallCount == CNT_W'($past(stallCount) + 1'b1))
    else $error("stolen-cycle counter missed a stalled cycle");

  p_count_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cpuStall |=> $stable(stallCount))
    else $error("stolen-cycle counter moved without a stall");

  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    oamWe |-> $past(dmaRd))
    else $error("sprite write not preceded by a bus read");

  p_write_spaced_r4: assert property (@(posedge clk) disable iff (!rstN)
    oamWe |=> !oamWe)
    else $error("back-to-back sprite writes");

  p_valid_after_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    smpValid |-> $past(dmaRd))
    else $error("sample byte valid without a preceding bus read");

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    smpValid |=> !smpValid)
    else $error("sample valid longer than one cycle");

endmodule

bind dma_steal_arb dma_steal_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuStall  (cpuStall),
  .dmaRd     (dmaRd),
  .oamWe     (oamWe),
  .smpValid  (smpValid),
  .stallCount(stallCount)
);

// File: tb/dma_steal_arb_bench.sv
module dma_steal_arb_bench;

  localparam int CLK_HALF = 10;  // 50 MHz
  localparam int WD_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuRnW = 1'b1;
  logic        oddCycle = 1'b0;
  logic        sprTrig = 1'b0;
  logic [7:0]  sprPage = '0;
  logic        smpEmpty = 1'b0;
  logic        smpRemain = 1'b0;
  logic        smpLoad = 1'b0;
  logic [15:0] smpLoadAddr = '0;
  logic [7:0]  memRdata;
  logic        cpuStall, dmaRd, oamWe, smpValid;
  logic [15:0] dmaAddr, stallCount;
  logic [7:0]  oamAddr, oamWdata, smpByte;

  int checks = 0;
  int errors = 0;
  logic [15:0] expAddr = 16'h8000;

  always #(CLK_HALF) clk = ~clk;
  always @(negedge clk) oddCycle <= ~oddCycle;

  function automatic logic [7:0] memByte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] nextAddr(logic [15:0] a);
    return (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
  endfunction

  // extra cycles a sample fetch adds at landing position p (0 = first stalled cycle)
  function automatic int sprExtra(bit startOdd, int p);
    int q;
    if (p == 0) return 2;
    if (startOdd && p == 1) return 1;
    q = startOdd ? p - 2 : p - 1;
    if (q >= 510) return 3;
    return 2;
  endfunction

  assign memRdata = memByte(dmaAddr);

  dma_steal_arb u_dma_steal_arb (
    .clk(clk), .rstN(rstN), .cpuRnW(cpuRnW), .oddCycle(oddCycle),
    .sprTrig(sprTrig), .sprPage(sprPage), .smpEmpty(smpEmpty),
    .smpRemain(smpRemain), .smpLoad(smpLoad), .smpLoadAddr(smpLoadAddr),
    .memRdata(memRdata), .cpuStall(cpuStall), .dmaRd(dmaRd),
    .dmaAddr(dmaAddr), .oamWe(oamWe), .oamAddr(oamAddr),
    .oamWdata(oamWdata), .smpByte(smpByte), .smpValid(smpValid),
    .stallCount(stallCount)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // one sample fetch landing outside a copy
  task automatic runSmp(bit rnw);
    logic [15:0] c0;
    int got;
    int expCost;
    string tag;
    tag = rnw ? "R2" : "R3";
    expCost = rnw ? 4 : 3;
    step();
    c0 = stallCount;
    cpuRnW = rnw;
    smpEmpty = 1'b1;
    smpRemain = 1'b1;
    #1;
    check(cpuStall == 1'b0, "R1", "stall in request cycle", cpuStall, 0);
    step();
    check(cpuStall == rnw, tag, "stall in landing cycle", cpuStall, rnw);
    got = 0;
    for (int i = 0; i < 12; i++) begin
      if (dmaRd) check(dmaAddr == expAddr, "R11", "sample address", dmaAddr, expAddr);
      if (smpValid) begin
        check(smpByte == memByte(expAddr), "R10", "sample byte", smpByte, memByte(expAddr));
        expAddr = nextAddr(expAddr);
        got++;
        smpEmpty = 1'b0;
      end
      step();
    end
    check(16'(stallCount - c0) == expCost, tag, "stolen cycles", 16'(stallCount - c0), expCost);
    check(got == 1, "R10", "bytes delivered", got, 1);
  endtask

  // one copy, optionally with a sample request landing at position landP
  task automatic runSpr(bit startOdd, bit doSmp, int landP, string tag);
    logic [15:0] c0;
    logic [7:0] pg;
    int wr, got, bad, badAct, badExp, expCost;
    pg = 8'($urandom);
    step();
    while (oddCycle == startOdd) step();
    c0 = stallCount;
    sprTrig = 1'b1;
    sprPage = pg;
    cpuRnW = 1'b0;
    wr = 0; got = 0; bad = 0; badAct = 0; badExp = 0;
    for (int c = 0; c < 540; c++) begin
      if (c == 1) sprTrig = 1'b0;
      if (doSmp && c == landP) begin
        smpEmpty = 1'b1;
        smpRemain = 1'b1;
      end
      if (oamWe) begin
        if (oamAddr != 8'(wr) || oamWdata != memByte({pg, 8'(wr)})) begin
          if (bad == 0) begin
            badAct = {oamAddr, oamWdata};
            badExp = {8'(wr), memByte({pg, 8'(wr)})};
          end
          bad++;
        end
        wr++;
      end
      if (smpValid) begin
        check(smpByte == memByte(expAddr), "R10", "sample byte in copy", smpByte, memByte(expAddr));
        expAddr = nextAddr(expAddr);
        got++;
        smpEmpty = 1'b0;
      end
      step();
    end
    expCost = 513 + int'(startOdd) + (doSmp ? sprExtra(startOdd, landP) : 0);
    check(bad == 0, "R9", "sprite index/data order", badAct, badExp);
    check(wr == 256, "R4", "sprite writes", wr, 256);
    check(16'(stallCount - c0) == expCost, tag, "copy stolen cycles", 16'(stallCount - c0), expCost);
    check(got == int'(doSmp), "R10", "bytes in copy", got, int'(doSmp));
  endtask

  initial begin
    #(2 * CLK_HALF * WD_CYCLES);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    int act;
    bit so;
    int p;
    void'($urandom(32'd2024));
    repeat (3) step();
    rstN = 1'b1;
    step();
    // reset state
    check(cpuStall == 1'b0, "R12", "reset stall", cpuStall, 0);
    check(stallCount == 16'd0, "R12", "reset counter", stallCount, 0);
    check(dmaRd == 1'b0 && oamWe == 1'b0, "R4", "reset bus idle", {dmaRd, oamWe}, 0);
    check(smpValid == 1'b0, "R10", "reset valid", smpValid, 0);

    // directed landings on read and write
    runSmp(1'b1);
    runSmp(1'b0);

    // empty buffer with nothing left to play is ignored (R13)
    step();
    c0 = stallCount;
    smpEmpty = 1'b1;
    smpRemain = 1'b0;
    cpuRnW = 1'b1;
    act = 0;
    for (int i = 0; i < 10; i++) begin
      if (cpuStall || dmaRd || smpValid) act++;
      step();
    end
    smpEmpty = 1'b0;
    check(act == 0, "R13", "activity with no bytes left", act, 0);
    check(stallCount == c0, "R13", "counter with no bytes left", stallCount, c0);

    // address wrap (R11)
    smpLoadAddr = 16'hFFFF;
    smpLoad = 1'b1;
    step();
    smpLoad = 1'b0;
    expAddr = 16'hFFFF;
    runSmp(1'b1);
    check(expAddr == 16'h8000, "R11", "model wrapped", expAddr, 16'h8000);
    runSmp(1'b0);

    // copies, both parities, no fetch (R5)
    runSpr(1'b0, 1'b0, 0, "R5");
    runSpr(1'b1, 1'b0, 0, "R5");
    // landing positions inside a copy
    runSpr(1'b0, 1'b1, 0, "R6");
    runSpr(1'b0, 1'b1, 200, "R6");
    runSpr(1'b0, 1'b1, 101, "R6");
    runSpr(1'b1, 1'b1, 1, "R7");
    runSpr(1'b0, 1'b1, 512, "R8");
    runSpr(1'b0, 1'b1, 511, "R8");
    runSpr(1'b1, 1'b1, 513, "R8");

    // random landings outside and inside copies
    for (int i = 0; i < 16; i++) runSmp(1'($urandom));
    for (int i = 0; i < 6; i++) begin
      so = 1'($urandom);
      p = int'($urandom % (so ? 514 : 513));
      runSpr(so, 1'b1, p, (so && p == 1) ? "R7" : (sprExtra(so, p) == 3 ? "R8" : "R6"));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule